// File: doc/BRIEF.md
# Accumulator ALU with Carry, Auxiliary-Carry and Overflow Flags

This block is the 8-bit execution core of a small accumulator machine. It holds a registered accumulator A, a second register B and three flags: carry (CY), auxiliary carry (AC, the carry or borrow across bit 3) and overflow (OV). Each cycle, a one-cycle operation strobe with an operation code and an 8-bit operand starts one operation. The result is written into A (and B for multiply and divide) and into the flags at the next clock edge. Instruction decode and memory access are left to the surrounding logic, which presents the operand byte and takes the memory byte produced by the low-nibble exchange.

The block accepts a new operation every cycle. It has no ready signal, so the operation input never applies back-pressure. The exchanged memory byte leaves on `mem_out`, qualified by `mem_valid`. `mem_valid` is high for exactly the one cycle after the exchange. The consumer must take the byte in that cycle, because the block cannot be stalled. `mem_out` keeps the last exchanged byte until the next exchange.

Arithmetic ops chain through CY. Add-with-carry lets two byte adds form a 16-bit add. Decimal adjust fixes a packed BCD sum. Rotate-through-carry treats CY as a ninth bit.

Top module: `acc_alu`

## Requirements
- R1: After reset is asserted (active low), A, B, CY, AC, OV, `mem_out` and `mem_valid` are all zero.
- R2: Code 1 (add) writes A+operand into A. Code 2 (add-with-carry) writes A+operand+CY into A. Both set CY from the carry out of bit 7 and AC from the carry out of bit 3. Both set OV when two operands of the same sign give a result of the other sign.
- R3: Code 3 (subtract-with-borrow) writes A−operand−CY (mod 256) into A. CY is set on a borrow out of bit 7 and AC on a borrow out of bit 3. OV is set on signed overflow.
- R4: Code 4 (decimal adjust) first adds 06h if A[3:0] > 9 or AC is set. It then adds 60h if the high nibble exceeds 9 or a carry is pending (either CY was set or the first step carried out). In that case CY is set. CY is never cleared by this operation, and AC and OV keep their values.
- R5: Code 5 (increment) and code 6 (decrement) change A by one, modulo 256, and leave all flags unchanged.
- R6: Codes 7, 8 and 9 write A AND, OR and XOR the operand into A. Code 10 writes NOT A and code 11 writes zero into A. None of them changes a flag.
- R7: Code 12 rotates A left and code 14 rotates A right, without touching CY. Code 13 rotates left and code 15 rotates right through the 9-bit ring {CY, A}.
- R8: Code 16 exchanges A[7:4] with A[3:0] and leaves the flags unchanged.
- R9: Code 17 (low-nibble exchange) writes {A[7:4], operand[3:0]} into A. It drives `mem_out` with {operand[7:4], old A[3:0]} and raises `mem_valid` for exactly the following cycle.
- R10: Code 18 (multiply) writes the product A×B with its low byte in A and its high byte in B. It sets OV when the product exceeds 255 and clears CY.
- R11: Code 19 (divide) writes the quotient A/B into A and the remainder into B, clearing OV and CY. When B is zero, A and B keep their values, OV is set and CY is cleared.
- R12: Code 20 loads the operand into A and code 21 loads it into B, leaving the flags unchanged.
- R13: When `op_valid` is low, or the code is 0 or any value from 22 to 31, A, B, the flags and `mem_out` keep their values and `mem_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | One-cycle strobe: perform `op_code` this cycle |
| op_code | input | 5 | Operation select (codes as in the requirements) |
| operand | input | 8 | Operand or memory byte |
| acc | output | 8 | Accumulator A |
| breg | output | 8 | Register B |
| cy | output | 1 | Carry / borrow flag |
| ac | output | 1 | Auxiliary carry flag |
| ov | output | 1 | Overflow flag |
| mem_out | output | 8 | Memory byte produced by the low-nibble exchange |
| mem_valid | output | 1 | High for the one cycle after an exchange |

## Verification
The bench targets several corner cases, each tied to a typical fault:
- Sign-boundary adds (7Fh+1, 80h+80h) and the borrow from zero. A design that took OV from the carry alone, or inverted the borrow sense, would show wrong CY, AC or OV here.
- Decimal adjust after a nibble carry (49h+38h), and with CY already set. A design that cleared CY, or skipped the low-nibble fix when only AC was set, would produce a non-BCD accumulator.
- Divide by zero and a multiply overflowing into B. A design that corrupted A or B, or left CY set, would fail these.
- Random codes including undefined ones and idle cycles. These expose any state that changes when it should hold, or a `mem_valid` pulse that lingers past one cycle.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [4:0] {
    OP_NOP  = 5'd0,  OP_ADD  = 5'd1,  OP_ADDC = 5'd2,  OP_SUBB = 5'd3,
    OP_DA   = 5'd4,  OP_INC  = 5'd5,  OP_DEC  = 5'd6,  OP_AND  = 5'd7,
    OP_OR   = 5'd8,  OP_XOR  = 5'd9,  OP_CPL  = 5'd10, OP_CLR  = 5'd11,
    OP_RL   = 5'd12, OP_RLC  = 5'd13, OP_RR   = 5'd14, OP_RRC  = 5'd15,
    OP_SWAP = 5'd16, OP_XCHD = 5'd17, OP_MUL  = 5'd18, OP_DIV  = 5'd19,
    OP_LDA  = 5'd20, OP_LDB  = 5'd21
  } alu_op_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } alu_flags_t;
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] opd,
  input  logic          cy_in,
  input  logic          ac_in,
  input  logic          sub,
  input  logic          use_cy,
  output logic [DW-1:0] sum,
  output logic          cy_o,
  output logic          ac_o,
  output logic          ov_o,
  output logic [DW-1:0] da_val,
  output logic          da_cy
);
  localparam int NW = DW / 2;

  logic [DW-1:0] y;
  logic          ci;
  logic [NW:0]   lo_sum;
  logic [DW-1:0] mid_sum;
  logic [DW:0]   full_sum;
  logic          c_lo, c_mid, c_full;

  // Subtraction is done as A + ~opd + ~CY; the carries are inverted to borrows.
  always_comb begin
    y        = sub ? ~opd : opd;
    ci       = sub ? ~cy_in : (use_cy & cy_in);
    lo_sum   = {1'b0, a[NW-1:0]} + {1'b0, y[NW-1:0]} + {{NW{1'b0}}, ci};
    mid_sum  = {1'b0, a[DW-2:0]} + {1'b0, y[DW-2:0]} + {{(DW-1){1'b0}}, ci};
    full_sum = {1'b0, a} + {1'b0, y} + {{DW{1'b0}}, ci};
    c_lo     = lo_sum[NW];
    c_mid    = mid_sum[DW-1];
    c_full   = full_sum[DW];
    sum      = full_sum[DW-1:0];
    cy_o     = sub ? ~c_full : c_full;
    ac_o     = sub ? ~c_lo : c_lo;
    ov_o     = c_mid ^ c_full;
  end

  logic          lo_fix, hi_fix, pend;
  logic [DW:0]   t1;

  always_comb begin
    lo_fix = ac_in || (a[NW-1:0] > NW'(9));
    t1     = {1'b0, a} + (lo_fix ? (DW+1)'(6) : (DW+1)'(0));
    pend   = cy_in | t1[DW];
    hi_fix = pend || (t1[DW-1:NW] > NW'(9));
    da_val = t1[DW-1:0] + (hi_fix ? (DW'(6) << NW) : DW'(0));
    da_cy  = pend | hi_fix;
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [4:0]    op_code,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] opd,
  input  logic          cy_in,
  output logic [DW-1:0] a_nx,
  output logic          cy_nx,
  output logic [DW-1:0] mem_nx
);
  localparam int NW = DW / 2;

  always_comb begin
    a_nx   = a;
    cy_nx  = cy_in;
    mem_nx = {opd[DW-1:NW], a[NW-1:0]};
    case (op_code)
      OP_INC:  a_nx = a + DW'(1);
      OP_DEC:  a_nx = a - DW'(1);
      OP_AND:  a_nx = a & opd;
      OP_OR:   a_nx = a | opd;
      OP_XOR:  a_nx = a ^ opd;
      OP_CPL:  a_nx = ~a;
      OP_CLR:  a_nx = '0;
      OP_RL:   a_nx = {a[DW-2:0], a[DW-1]};
      OP_RR:   a_nx = {a[0], a[DW-1:1]};
      OP_RLC:  {cy_nx, a_nx} = {a, cy_in};
      OP_RRC:  {a_nx, cy_nx} = {cy_in, a};
      OP_SWAP: a_nx = {a[NW-1:0], a[DW-1:NW]};
      OP_XCHD: a_nx = {a[DW-1:NW], opd[NW-1:0]};
      default: a_nx = a;
    endcase
  end
endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] mul_lo,
  output logic [DW-1:0] mul_hi,
  output logic          mul_ov,
  output logic [DW-1:0] quo,
  output logic [DW-1:0] rem,
  output logic          div_zero
);
  logic [2*DW-1:0] prod;

  always_comb begin
    prod     = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
    mul_lo   = prod[DW-1:0];
    mul_hi   = prod[2*DW-1:DW];
    mul_ov   = |mul_hi;
    div_zero = (b == '0);
    // Divide by zero holds both registers, so stable values are presented.
    quo      = div_zero ? a : a / b;
    rem      = div_zero ? b : a % b;
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [4:0]    op_code,
  input  logic [DW-1:0] operand,
  output logic [DW-1:0] acc,
  output logic [DW-1:0] breg,
  output logic          cy,
  output logic          ac,
  output logic          ov,
  output logic [DW-1:0] mem_out,
  output logic          mem_valid
);
  localparam int NW = DW / 2;

  logic [DW-1:0] acc_q, b_q, mem_q;
  alu_flags_t    fl_q;
  logic          mem_vld_q;

  logic [DW-1:0] acc_n, b_n, mem_n;
  alu_flags_t    fl_n;
  logic          mem_vld_n;

  logic [DW-1:0] ar_sum, ar_da;
  logic          ar_cy, ar_ac, ar_ov, ar_dacy, is_sub, is_addc;
  logic [DW-1:0] lg_a, lg_mem;
  logic          lg_cy;
  logic [DW-1:0] md_lo, md_hi, md_q, md_r;
  logic          md_ov, md_dz;

  assign is_sub  = (op_code == OP_SUBB);
  assign is_addc = (op_code == OP_ADDC);

  acc_alu_arith #(.DW(DW)) u_arith (
    .a(acc_q), .opd(operand), .cy_in(fl_q.cy), .ac_in(fl_q.ac),
    .sub(is_sub), .use_cy(is_addc), .sum(ar_sum), .cy_o(ar_cy),
    .ac_o(ar_ac), .ov_o(ar_ov), .da_val(ar_da), .da_cy(ar_dacy)
  );

  acc_alu_logic #(.DW(DW)) u_logic (
    .op_code(op_code), .a(acc_q), .opd(operand), .cy_in(fl_q.cy),
    .a_nx(lg_a), .cy_nx(lg_cy), .mem_nx(lg_mem)
  );

  acc_alu_muldiv #(.DW(DW)) u_muldiv (
    .a(acc_q), .b(b_q), .mul_lo(md_lo), .mul_hi(md_hi), .mul_ov(md_ov),
    .quo(md_q), .rem(md_r), .div_zero(md_dz)
  );

  always_comb begin
    acc_n     = acc_q;
    b_n       = b_q;
    fl_n      = fl_q;
    mem_n     = mem_q;
    mem_vld_n = 1'b0;
    if (op_valid) begin
      case (op_code)
        OP_ADD, OP_ADDC, OP_SUBB: begin
          acc_n = ar_sum;
          fl_n  = '{cy: ar_cy, ac: ar_ac, ov: ar_ov};
        end
        OP_DA: begin
          acc_n   = ar_da;
          fl_n.cy = ar_dacy;
        end
        OP_INC, OP_DEC, OP_AND, OP_OR, OP_XOR, OP_CPL, OP_CLR,
        OP_RL, OP_RLC, OP_RR, OP_RRC, OP_SWAP: begin
          acc_n   = lg_a;
          fl_n.cy = lg_cy;
        end
        OP_XCHD: begin
          acc_n     = lg_a;
          mem_n     = lg_mem;
          mem_vld_n = 1'b1;
        end
        OP_MUL: begin
          acc_n   = md_lo;
          b_n     = md_hi;
          fl_n.cy = 1'b0;
          fl_n.ov = md_ov;
        end
        OP_DIV: begin
          acc_n   = md_q;
          b_n     = md_r;
          fl_n.cy = 1'b0;
          fl_n.ov = md_dz;
        end
        OP_LDA: acc_n = operand;
        OP_LDB: b_n   = operand;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      b_q       <= '0;
      fl_q      <= '0;
      mem_q     <= '0;
      mem_vld_q <= 1'b0;
    end else begin
      acc_q     <= acc_n;
      b_q       <= b_n;
      fl_q      <= fl_n;
      mem_q     <= mem_n;
      mem_vld_q <= mem_vld_n;
    end
  end

  assign acc       = acc_q;
  assign breg      = b_q;
  assign cy        = fl_q.cy;
  assign ac        = fl_q.ac;
  assign ov        = fl_q.ov;
  assign mem_out   = mem_q;
  assign mem_valid = mem_vld_q;

  // R4: decimal adjust may set the carry but never clear it
  assert_da_keeps_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_DA && cy) |=> cy);

  // R5: increment and decrement leave every flag alone
  assert_incdec_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_INC || op_code == OP_DEC)) |=> $stable({cy, ac, ov}));

  // R7: rotate-left through carry moves old CY into bit 0 and old bit 7 into CY
  assert_rlc_ring_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_RLC) |=> (acc[0] == $past(cy)) && (cy == $past(acc[DW-1])));

  // R8: nibble swap
  assert_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_SWAP) |=>
      (acc == {$past(acc[NW-1:0]), $past(acc[DW-1:NW])}));

  // R9: exchange pulses mem_valid once with the operand's upper nibble kept
  assert_xchd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_XCHD) |=>
      mem_valid && (mem_out[DW-1:NW] == $past(operand[DW-1:NW])) &&
      (mem_out[NW-1:0] == $past(acc[NW-1:0])));

  assert_mem_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !(op_valid && op_code == OP_XCHD)) |=> !mem_valid);

  // R10: multiply clears the carry
  assert_mul_clears_cy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_MUL) |=> !cy);

  // R11: divide by zero raises OV and holds A and B
  assert_div_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_DIV && breg == '0) |=>
      ov && !cy && $stable(acc) && $stable(breg));

  // R13: idle cycles leave the state untouched
  assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid) |=> $stable({acc, breg, cy, ac, ov, mem_out}) && !mem_valid);
endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic [7:0] operand = '0;
  logic [7:0] acc, breg, mem_out;
  logic       cy, ac, ov, mem_valid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int ma, mb, mmem;
  bit mcy, mac, mov, mvld;

  always #5 clk = ~clk;

  acc_alu u_acc_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .acc(acc), .breg(breg), .cy(cy), .ac(ac), .ov(ov),
    .mem_out(mem_out), .mem_valid(mem_valid)
  );

  function automatic string tag_of(input int code, input bit vld);
    if (!vld || code == 0 || code > 21) return "R13";
    case (code)
      1, 2:   return "R2";
      3:      return "R3";
      4:      return "R4";
      5, 6:   return "R5";
      7, 8, 9, 10, 11: return "R6";
      12, 13, 14, 15:  return "R7";
      16:     return "R8";
      17:     return "R9";
      18:     return "R10";
      19:     return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  task automatic model_step(input int code, input int opd);
    int s, sr, x, p;
    bit c;
    mvld = 0;
    case (code)
      1, 2: begin
        c   = (code == 2) ? mcy : 1'b0;
        s   = ma + opd + int'(c);
        sr  = sgn(ma) + sgn(opd) + int'(c);
        mac = ((ma % 16) + (opd % 16) + int'(c)) > 15;
        mov = (sr > 127) || (sr < -128);
        mcy = s > 255;
        ma  = s % 256;
      end
      3: begin
        s   = ma - opd - int'(mcy);
        sr  = sgn(ma) - sgn(opd) - int'(mcy);
        mac = (ma % 16) < ((opd % 16) + int'(mcy));
        mov = (sr > 127) || (sr < -128);
        mcy = s < 0;
        ma  = (s + 256) % 256;
      end
      4: begin
        x = ma;
        if ((x % 16) > 9 || mac) x = x + 6;
        c = mcy || (x > 255);
        x = x % 256;
        if ((x / 16) > 9 || c) begin
          x = (x + 96) % 256;
          c = 1'b1;
        end
        ma = x; mcy = c;
      end
      5:  ma = (ma + 1) % 256;
      6:  ma = (ma + 255) % 256;
      7:  ma = ma & opd;
      8:  ma = ma | opd;
      9:  ma = ma ^ opd;
      10: ma = 255 - ma;
      11: ma = 0;
      12: ma = ((ma * 2) % 256) + (ma / 128);
      13: begin c = (ma >= 128); ma = ((ma * 2) % 256) + int'(mcy); mcy = c; end
      14: ma = (ma / 2) + 128 * (ma % 2);
      15: begin c = (ma % 2) == 1; ma = (ma / 2) + 128 * int'(mcy); mcy = c; end
      16: ma = (ma % 16) * 16 + (ma / 16);
      17: begin
        mmem = (opd / 16) * 16 + (ma % 16);
        ma   = (ma / 16) * 16 + (opd % 16);
        mvld = 1;
      end
      18: begin p = ma * mb; ma = p % 256; mb = p / 256; mov = p > 255; mcy = 0; end
      19: begin
        mcy = 0;
        if (mb == 0) mov = 1;
        else begin p = ma; ma = p / mb; mb = p % mb; mov = 0; end
      end
      20: ma = opd;
      21: mb = opd;
      default: ;
    endcase
  endtask

  task automatic check_all(input string tag);
    logic [27:0] got, exp;
    got = {acc, breg, cy, ac, ov, mem_valid, mem_out};
    exp = {8'(ma), 8'(mb), mcy, mac, mov, mvld, 8'(mmem)};
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: acc/b/cy/ac/ov/mvld/mem actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic do_op(input bit vld, input int code, input int opd);
    @(negedge clk);
    op_valid = vld;
    op_code  = 5'(code);
    operand  = 8'(opd);
    @(negedge clk);
    op_valid = 1'b0;
    if (vld) model_step(code, opd);
    else mvld = 0;
    check_all(tag_of(code, vld));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int r;
    ma = 0; mb = 0; mmem = 0; mcy = 0; mac = 0; mov = 0; mvld = 0;
    r = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    // R2: signed boundary and carry out
    do_op(1, 20, 8'h7F); do_op(1, 1, 8'h01);
    do_op(1, 20, 8'h80); do_op(1, 1, 8'h80);
    do_op(1, 20, 8'hFF); do_op(1, 1, 8'h01);
    do_op(1, 2, 8'h10);
    // R3: borrow from zero
    do_op(1, 20, 8'h00); do_op(1, 11, 0); do_op(1, 3, 8'h01);
    do_op(1, 3, 8'h7F);
    // R4: BCD adjust with nibble carry, and with CY already set
    do_op(1, 20, 8'h49); do_op(1, 1, 8'h38); do_op(1, 4, 0);
    do_op(1, 20, 8'h99); do_op(1, 1, 8'h99); do_op(1, 4, 0);
    // R7: rotates through carry
    do_op(1, 13, 0); do_op(1, 15, 0); do_op(1, 12, 0); do_op(1, 14, 0);
    // R9: exchange then idle
    do_op(1, 20, 8'hA5); do_op(1, 17, 8'h3C); do_op(0, 17, 8'h00);
    // R10 / R11: multiply overflow, divide, divide by zero
    do_op(1, 20, 8'h50); do_op(1, 21, 8'hA0); do_op(1, 18, 0);
    do_op(1, 20, 8'hFB); do_op(1, 21, 8'h12); do_op(1, 19, 0);
    do_op(1, 21, 8'h00); do_op(1, 19, 0);
    // R5: wrap
    do_op(1, 20, 8'hFF); do_op(1, 5, 0); do_op(1, 6, 0);
    // R13: undefined code
    do_op(1, 27, 8'h55);
    for (int i = 0; i < 4000; i++) begin
      int code, opd;
      bit vld;
      code = int'($urandom % 32);
      opd  = int'($urandom % 256);
      vld  = ($urandom % 8) != 0;
      do_op(vld, code, opd);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule